// File: doc/BRIEF.md
# Modulo Circular-Buffer Address Generator

This block works out the effective address of one register-indirect data access whose pointer walks a circular buffer. The buffer is framed by a lower boundary (the address of its first word) and an upper boundary (the address of its last word). Each request brings the current pointer value, a signed byte step, an addressing mode and the number of the pointer register in use. One cycle later the block returns the address for the access, together with the value to write back into the pointer and a strobe that says whether that write happens.

Wrapping is decided from the sign of the step. A step of zero or more checks the sum against the upper boundary. A negative step checks the sum against the lower boundary. The test is an ordered comparison, so strides of several words that land past a boundary are still folded back by exactly one buffer length. The correction only applies when modulo addressing is enabled and the request names the pointer register that is assigned to modulo addressing. In every other case the plain linear address passes through unchanged.

Top module: `modulo_agu`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` and `out_wb_we` are 0.
- R2: With a step of zero or more, a linear sum (pointer plus step) that is greater than `buf_hi` is reduced by the buffer length, where length = `buf_hi` − `buf_lo` + 2 bytes (one word).
- R3: With a negative step, a linear sum that is less than `buf_lo` is increased by the buffer length.
- R4: Only a sum strictly beyond a boundary wraps. A sum equal to `buf_hi` or to `buf_lo` is used unchanged.
- R5: A stride larger than one word (up to one buffer length) that jumps past a boundary wraps to the same address that single-word steps would reach.
- R6: Mode 2'b00 (post-modify): `out_ea` is the unmodified pointer, `out_wb` is the wrapped sum, and `out_wb_we` = 1.
- R7: Mode 2'b01 (pre-modify): `out_ea` and `out_wb` are both the wrapped sum, and `out_wb_we` = 1.
- R8: Mode 2'b10 (register plus offset): `out_ea` is the wrapped sum, `out_wb_we` = 0, and `out_wb` holds the unchanged pointer.
- R9: Mode 2'b11 (plain indirect): the step is ignored, `out_ea` = `out_wb` = pointer, and `out_wb_we` = 0.
- R10: When `mod_en` = 0, or `req_sel` ≠ `mod_sel`, the linear sum is used with no wrap.
- R11: Results appear exactly one clock after `req_valid`. `out_valid` follows `req_valid` with a delay of one cycle, and `out_wb_we` is never 1 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | Addressing mode (00 post, 01 pre, 10 offset, 11 plain) |
| req_sel | input | PSEL_W | Pointer register number of the access |
| req_ptr | input | AW | Current pointer value (byte address) |
| req_step | input | AW | Signed byte step or offset |
| mod_en | input | 1 | Modulo addressing enable |
| mod_sel | input | PSEL_W | Pointer register assigned to modulo addressing |
| buf_lo | input | AW | Address of the first word of the buffer |
| buf_hi | input | AW | Address of the last word of the buffer |
| out_valid | output | 1 | Result valid |
| out_ea | output | AW | Effective address for the access |
| out_wb | output | AW | Pointer write-back value |
| out_wb_we | output | 1 | Pointer write-back strobe |

## Verification
Two functions can fall in the same cycle: the boundary wrap, and the split between access address and write-back in post-modify mode. In that case the access must use the old pointer while the write-back carries the folded value. The bench sets this up by placing the pointer on the last word and stepping forward, and on the first word and stepping back. It then checks that `out_ea` holds the raw pointer while `out_wb` holds the opposite end of the buffer. A strided walk that feeds each write-back into the next request is compared, step by step, against a reference model in the bench.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_POST  = 2'b00,
    AM_PRE   = 2'b01,
    AM_OFFS  = 2'b10,
    AM_PLAIN = 2'b11
  } am_mode_e;
endpackage

// File: rtl/agu_linear.sv
module agu_linear #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] step,
  input  logic          use_step,
  output logic [AW-1:0] sum,
  output logic          step_neg
);
  always_comb begin
    sum      = use_step ? (base + step) : base;
    step_neg = use_step & step[AW-1];
  end
endmodule

// File: rtl/agu_wrap.sv
module agu_wrap #(
  parameter int AW         = 16,
  parameter int WORD_BYTES = 2
) (
  input  logic [AW-1:0] lin,
  input  logic          step_neg,
  input  logic          active,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] addr
);
  localparam logic [AW-1:0] WB = AW'(WORD_BYTES);
  logic [AW-1:0] len;
  logic          above, below;

  always_comb begin
    len   = hi - lo + WB;
    above = !step_neg && (lin > hi);
    below =  step_neg && (lin < lo);
    if (active && above)      addr = lin - len;
    else if (active && below) addr = lin + len;
    else                      addr = lin;
  end
endmodule

// File: rtl/modulo_agu.sv
module modulo_agu
  import agu_pkg::*;
#(
  parameter int AW         = 16,
  parameter int NPTR       = 16,
  parameter int WORD_BYTES = 2,
  localparam int PSEL_W    = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [PSEL_W-1:0] req_sel,
  input  logic [AW-1:0]     req_ptr,
  input  logic [AW-1:0]     req_step,
  input  logic              mod_en,
  input  logic [PSEL_W-1:0] mod_sel,
  input  logic [AW-1:0]     buf_lo,
  input  logic [AW-1:0]     buf_hi,
  output logic              out_valid,
  output logic [AW-1:0]     out_ea,
  output logic [AW-1:0]     out_wb,
  output logic              out_wb_we
);
  am_mode_e      mode;
  logic          use_step, step_neg, active;
  logic [AW-1:0] lin, wrapped;
  logic [AW-1:0] ea_d, wb_d;
  logic          we_d;

  assign mode     = am_mode_e'(req_mode);
  assign use_step = (mode != AM_PLAIN);
  assign active   = mod_en && (req_sel == mod_sel);

  agu_linear #(.AW(AW)) u_lin (
    .base(req_ptr), .step(req_step), .use_step(use_step),
    .sum(lin), .step_neg(step_neg)
  );

  agu_wrap #(.AW(AW), .WORD_BYTES(WORD_BYTES)) u_wrap (
    .lin(lin), .step_neg(step_neg), .active(active),
    .lo(buf_lo), .hi(buf_hi), .addr(wrapped)
  );

  always_comb begin
    unique case (mode)
      AM_POST:  begin ea_d = req_ptr; wb_d = wrapped; we_d = 1'b1; end
      AM_PRE:   begin ea_d = wrapped; wb_d = wrapped; we_d = 1'b1; end
      AM_OFFS:  begin ea_d = wrapped; wb_d = req_ptr; we_d = 1'b0; end
      default:  begin ea_d = req_ptr; wb_d = req_ptr; we_d = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wb_we <= 1'b0;
      out_ea    <= '0;
      out_wb    <= '0;
    end else begin
      out_valid <= req_valid;
      out_wb_we <= req_valid & we_d;
      if (req_valid) begin
        out_ea <= ea_d;
        out_wb <= wb_d;
      end
    end
  end

  // R11: strobe only with a valid result
  p_we_valid_r11: assert property (@(posedge clk) disable iff (rst)
    out_wb_we |-> out_valid);
  // R11: one-cycle latency
  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  // R8: offset mode never writes back
  p_offs_no_we_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b10) |=> !out_wb_we);
  // R6: post-modify accesses the old pointer
  p_post_ea_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b00) |=> (out_ea == $past(req_ptr)));
  // R7: pre-modify uses one address for both
  p_pre_same_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b01) |=> (out_ea == out_wb && out_wb_we));
  // R10: disabled modulo gives the linear sum
  p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !mod_en && req_mode == 2'b01) |=>
      (out_wb == $past(req_ptr + req_step)));
endmodule

// File: tb/sim_modulo_agu.sv
module sim_modulo_agu;
  localparam int AW = 16;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_mode = 2'b00;
  logic [PW-1:0] req_sel = '0;
  logic [AW-1:0] req_ptr = '0;
  logic [AW-1:0] req_step = '0;
  logic          mod_en = 1'b0;
  logic [PW-1:0] mod_sel = '0;
  logic [AW-1:0] buf_lo = 16'h1000;
  logic [AW-1:0] buf_hi = 16'h101E;
  logic          out_valid, out_wb_we;
  logic [AW-1:0] out_ea, out_wb;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  modulo_agu #(.AW(AW), .NPTR(16), .WORD_BYTES(2)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_sel(req_sel), .req_ptr(req_ptr), .req_step(req_step),
    .mod_en(mod_en), .mod_sel(mod_sel), .buf_lo(buf_lo), .buf_hi(buf_hi),
    .out_valid(out_valid), .out_ea(out_ea), .out_wb(out_wb), .out_wb_we(out_wb_we)
  );

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference: linear sum folded by one buffer length past a boundary
  function automatic logic [AW-1:0] ref_wrap(input logic [AW-1:0] p, input logic [AW-1:0] s,
                                             input logic act);
    logic [AW-1:0] sum, len;
    sum = p + s;
    len = buf_hi - buf_lo + 16'd2;
    if (act && !s[AW-1] && sum > buf_hi) return sum - len;
    if (act &&  s[AW-1] && sum < buf_lo) return sum + len;
    return sum;
  endfunction

  task automatic issue(input logic [1:0] m, input logic [PW-1:0] sel,
                       input logic [AW-1:0] p, input logic [AW-1:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_mode = m; req_sel = sel; req_ptr = p; req_step = s;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid in reset", {15'd0, out_valid}, 16'd0);
    check("R1 we in reset", {15'd0, out_wb_we}, 16'd0);
    @(negedge clk); rst = 1'b0;
    check("R1 valid after reset", {15'd0, out_valid}, 16'd0);
  endtask

  task automatic t_inc;
    issue(2'b00, 4'd3, 16'h101C, 16'd2);
    check("R4 equal upper no wrap", out_wb, 16'h101E);
    check("R11 valid", {15'd0, out_valid}, 16'd1);
    issue(2'b00, 4'd3, 16'h101E, 16'd2);
    check("R2 upper wrap wb", out_wb, 16'h1000);
    check("R6 post ea", out_ea, 16'h101E);
    check("R6 post we", {15'd0, out_wb_we}, 16'd1);
    @(negedge clk);
    check("R11 valid drops", {15'd0, out_valid}, 16'd0);
    check("R11 we drops", {15'd0, out_wb_we}, 16'd0);
  endtask

  task automatic t_dec;
    issue(2'b00, 4'd3, 16'h1002, 16'hFFFE);
    check("R4 equal lower no wrap", out_wb, 16'h1000);
    issue(2'b00, 4'd3, 16'h1000, 16'hFFFE);
    check("R3 lower wrap wb", out_wb, 16'h101E);
    check("R6 post ea dec", out_ea, 16'h1000);
  endtask

  task automatic t_stride;
    issue(2'b01, 4'd3, 16'h101C, 16'd6);
    check("R5 inc stride", out_wb, 16'h1002);
    issue(2'b01, 4'd3, 16'h1004, 16'hFFF8);
    check("R5 dec stride", out_wb, 16'h101C);
    issue(2'b01, 4'd3, 16'h1010, 16'd32);
    check("R5 full length stride", out_wb, 16'h1010);
  endtask

  task automatic t_modes;
    issue(2'b01, 4'd3, 16'h101E, 16'd4);
    check("R7 pre ea", out_ea, 16'h1002);
    check("R7 pre wb", out_wb, 16'h1002);
    check("R7 pre we", {15'd0, out_wb_we}, 16'd1);
    issue(2'b10, 4'd3, 16'h1018, 16'd10);
    check("R8 offset ea", out_ea, 16'h1002);
    check("R8 offset wb", out_wb, 16'h1018);
    check("R8 offset we", {15'd0, out_wb_we}, 16'd0);
    issue(2'b11, 4'd3, 16'h101E, 16'd8);
    check("R9 plain ea", out_ea, 16'h101E);
    check("R9 plain wb", out_wb, 16'h101E);
    check("R9 plain we", {15'd0, out_wb_we}, 16'd0);
  endtask

  task automatic t_bypass;
    issue(2'b01, 4'd5, 16'h101E, 16'd2);
    check("R10 other pointer", out_wb, 16'h1020);
    mod_en = 1'b0;
    issue(2'b01, 4'd3, 16'h1000, 16'hFFFE);
    check("R10 modulo off", out_wb, 16'h0FFE);
    mod_en = 1'b1;
  endtask

  task automatic t_walk;
    logic [AW-1:0] p, e;
    p = 16'h1000;
    for (int i = 0; i < 12; i++) begin
      e = ref_wrap(p, 16'd10, 1'b1);
      issue(2'b00, 4'd3, p, 16'd10);
      check("R5 walk up", out_wb, e);
      p = e;
    end
    for (int i = 0; i < 12; i++) begin
      e = ref_wrap(p, 16'hFFFA, 1'b1);
      issue(2'b00, 4'd3, p, 16'hFFFA);
      check("R5 walk down", out_wb, e);
      p = e;
    end
  endtask

  initial begin
    mod_en = 1'b1; mod_sel = 4'd3;
    repeat (3) @(negedge clk);
    t_reset();
    t_inc();
    t_dec();
    t_stride();
    t_modes();
    t_bypass();
    t_walk();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule